// File: doc/BRIEF.md
# Sprite Pattern ROM Address Generator

This block turns one sprite's stored attributes into the pattern ROM addresses that a line renderer fetches. It contains a small object store of up to 64 entries. Each entry has three byte lanes: vertical position, horizontal position and pattern code. The CPU fills the store through a decoded write window. A render request names one object and the current scan line. The block reads that object from the store, works out which of the sprite's sixteen rows falls on the line, and then emits the two byte addresses of that row on consecutive cycles, each with a valid strobe and the sprite's horizontal position.

The store hands back every byte bit-inverted. The block uses the inverted pattern code directly as the upper eight address bits and restores the two position bytes before using them. The full address is therefore the complemented code, then the four row bits, then the half-row bit. While no row is being emitted, the address sits at the top of the ROM, at 0x1FFE or 0x1FFF, where the pattern data is blank.

The CPU and the renderer share the store. The renderer owns it during active video, and CPU writes are taken only while the blanking input is high. Deciding which sprites are visible on a line happens outside this block, which simply serves the request it is given.

Top module: `spriteAddrGen`

## Requirements
- R1: After reset, `romValid` and `ramSel` are 0 and `romAddr[12:1]` equals 12'hFFF.
- R2: A CPU write lands only when `cpuWr` is 1, `cpuAddr[13:11]` is 3'b110 and `blank` is 1. `cpuAddr[7:2]` selects the object. `cpuAddr[1:0]` selects the lane: 0 is vertical position, 1 is horizontal position and 2 is pattern code. Lane 3 stores nothing and leaves the other lanes unchanged.
- R3: A write whose `cpuAddr[13:11]` is not 3'b110 changes no stored byte.
- R4: A write made while `blank` is 0 changes no stored byte.
- R5: For an emitted beat, `romAddr` equals {~code, row[3:0], half}, and `romX` equals the stored horizontal position. For example, code 0x28 on row 0 gives 0x1AE0.
- R6: A hit emits exactly two valid beats, on the second and third cycles after the request is sampled. The first beat has half 0 and the second has half 1, and both carry the same upper twelve bits.
- R7: Row is (scanLine − vertical position) mod 256, and the request hits only when that value is 0 to 15. On a miss, `romValid` stays 0 for the whole request.
- R8: `ramSel` is 1 for exactly the one cycle after a request is accepted, and it is 0 at all other times.
- R9: Whenever `romValid` is 0, `romAddr[12:1]` is 12'hFFF and `romX` is 0.
- R10: A request sampled while `blank` is 1 is dropped. A request sampled while a previous request is still in progress is also dropped.
- R11: Rendering the sixteen lines of one sprite, row 0 to 15, produces 32 consecutive addresses from base {~code, 5'b0} up to base + 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 14 | CPU byte address |
| cpuData | input | 8 | CPU write data |
| cpuWr | input | 1 | CPU write strobe, one cycle per write |
| blank | input | 1 | 1 during blanking (CPU owns the store), 0 during active video |
| renderReq | input | 1 | Render request pulse |
| renderObj | input | 6 | Object index to render |
| scanLine | input | 8 | Current scan line, sampled with the request |
| romAddr | output | 13 | Pattern ROM address |
| romValid | output | 1 | Address strobe for an emitted row byte |
| romX | output | 8 | Horizontal position of the sprite being emitted |
| ramSel | output | 1 | Object store select for the render read |

## Verification
The assertions assume that `blank` does not change while a render request is in progress. They also assume that the environment never pulses `renderReq` during blanking in a way that overlaps a CPU write. Under those conditions, a render read and a CPU write can never both be active. The bench drives every input at the falling edge. It changes `blank` only while the block is idle, and it spaces its requests four cycles apart except in the one deliberate back-to-back case. The sweeps cover every object over lines from two before to two after each sprite, which reaches both row boundaries and the 8-bit wrap. They also cover all 256 pattern codes on a single object.

// File: rtl/spraddr_pkg.sv
package spraddr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_BEAT0 = 2'd2,
    ST_BEAT1 = 2'd3
  } sprState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;  // latch object index and scan line
    logic fetch;   // object store read is live, latch attributes
    logic beat;    // emit a row byte address
    logic half;    // which byte of the row
  } sprStrobe_t;

  localparam int LANE_VPOS = 0;
  localparam int LANE_HPOS = 1;
  localparam int LANE_CODE = 2;
  localparam int LANE_COUNT = 3;

endpackage

// File: rtl/sprObjRam.sv
module sprObjRam
  import spraddr_pkg::*;
#(
  parameter int OBJ_COUNT = 64,
  parameter int BYTE_W    = 8,
  localparam int OBJ_W    = $clog2(OBJ_COUNT)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              wrEn,
  input  logic [OBJ_W-1:0]                  wrObj,
  input  logic [1:0]                        wrLane,
  input  logic [BYTE_W-1:0]                 wrData,
  input  logic                              rdSel,
  input  logic [OBJ_W-1:0]                  rdObj,
  output logic [LANE_COUNT-1:0][BYTE_W-1:0] rdBytes
);

  // one storage array per byte lane; the read port drives the complement
  for (genvar lane = 0; lane < LANE_COUNT; lane++) begin : gLane
    logic [BYTE_W-1:0] laneMem [OBJ_COUNT];

    always_ff @(posedge clk) begin
      if (wrEn && (wrLane == 2'(lane))) begin
        laneMem[wrObj] <= wrData;
      end
    end

    assign rdBytes[lane] = rdSel ? ~laneMem[rdObj] : {BYTE_W{1'b1}};
  end

  // R4: the store is never written and read for rendering in the same cycle
  a_r4_no_write_during_read: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && rdSel));

endmodule

// File: rtl/sprAddrCtrl.sv
module sprAddrCtrl
  import spraddr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       blank,
  input  logic       renderReq,
  output sprStrobe_t strobes,
  output logic       ramSel
);

  sprState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    case (state)
      ST_IDLE: begin
        if (renderReq && !blank) begin
          strobes.accept = 1'b1;
          stateNext      = ST_FETCH;
        end
      end
      ST_FETCH: begin
        strobes.fetch = 1'b1;
        stateNext     = ST_BEAT0;
      end
      ST_BEAT0: begin
        strobes.beat = 1'b1;
        stateNext    = ST_BEAT1;
      end
      ST_BEAT1: begin
        strobes.beat = 1'b1;
        strobes.half = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign ramSel = (state == ST_FETCH);

  // R8: an accepted request opens the store on the following cycle
  a_r8_accept_then_select: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accept |=> ramSel);

  // R10: nothing is accepted while the renderer has handed the store to the CPU
  a_r10_blank_no_accept: assert property (@(posedge clk) disable iff (!rstN)
    blank |-> !strobes.accept);

endmodule

// File: rtl/sprAddrPath.sv
module sprAddrPath
  import spraddr_pkg::*;
#(
  parameter int OBJ_COUNT = 64,
  parameter int POS_W     = 8,
  parameter int CODE_W    = 8,
  parameter int ROW_W     = 4,
  localparam int OBJ_W    = $clog2(OBJ_COUNT),
  localparam int ADDR_W   = CODE_W + ROW_W + 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  sprStrobe_t                       strobes,
  input  logic [OBJ_W-1:0]                 renderObj,
  input  logic [POS_W-1:0]                 scanLine,
  input  logic [LANE_COUNT-1:0][POS_W-1:0] rdBytes,
  output logic [OBJ_W-1:0]                 objIdx,
  output logic [ADDR_W-1:0]                romAddr,
  output logic                             romValid,
  output logic [POS_W-1:0]                 romX
);

  logic [POS_W-1:0]  lineReg;
  logic [CODE_W-1:0] codeReg;
  logic [ROW_W-1:0]  rowReg;
  logic [POS_W-1:0]  xReg;
  logic              hitReg;
  logic              idleHalf;
  logic [POS_W-1:0]  rowDiff;

  // store output is inverted: positions are restored, the code is used as read
  assign rowDiff = lineReg - ~rdBytes[LANE_VPOS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      objIdx   <= '0;
      lineReg  <= '0;
      codeReg  <= '0;
      rowReg   <= '0;
      xReg     <= '0;
      hitReg   <= 1'b0;
      idleHalf <= 1'b0;
    end else begin
      idleHalf <= ~idleHalf;
      if (strobes.accept) begin
        objIdx  <= renderObj;
        lineReg <= scanLine;
      end
      if (strobes.fetch) begin
        codeReg <= rdBytes[LANE_CODE][CODE_W-1:0];
        rowReg  <= rowDiff[ROW_W-1:0];
        hitReg  <= (rowDiff >> ROW_W) == '0;
        xReg    <= ~rdBytes[LANE_HPOS];
      end
    end
  end

  assign romValid = strobes.beat && hitReg;
  assign romAddr  = romValid ? {codeReg, rowReg, strobes.half}
                             : {{(ADDR_W-1){1'b1}}, idleHalf};
  assign romX     = romValid ? xReg : '0;

  // R6: a first-half beat is followed by the second half of the same row
  a_r6_half_order: assert property (@(posedge clk) disable iff (!rstN)
    (romValid && !romAddr[0]) |=> (romValid && romAddr[0] && $stable(romAddr[ADDR_W-1:1])));

  // R6: the second half ends the pair
  a_r6_pair_closed: assert property (@(posedge clk) disable iff (!rstN)
    (romValid && romAddr[0]) |=> !romValid);

  // R9: outside a beat the address stays in the blank pattern region
  a_r9_idle_region: assert property (@(posedge clk) disable iff (!rstN)
    !romValid |-> (romAddr[ADDR_W-1:1] == {(ADDR_W-1){1'b1}}));

endmodule

// File: rtl/spriteAddrGen.sv
module spriteAddrGen
  import spraddr_pkg::*;
#(
  parameter int          OBJ_COUNT = 64,
  parameter int          POS_W     = 8,
  parameter int          CODE_W    = 8,
  parameter int          ROW_W     = 4,
  parameter int          CPU_AW    = 14,
  parameter int          WIN_LO    = 11,
  parameter logic [2:0]  WIN_SEL   = 3'b110,
  localparam int         OBJ_W     = $clog2(OBJ_COUNT),
  localparam int         ADDR_W    = CODE_W + ROW_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic [POS_W-1:0]  cpuData,
  input  logic              cpuWr,
  input  logic              blank,
  input  logic              renderReq,
  input  logic [OBJ_W-1:0]  renderObj,
  input  logic [POS_W-1:0]  scanLine,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romValid,
  output logic [POS_W-1:0]  romX,
  output logic              ramSel
);

  sprStrobe_t                       strobes;
  logic [OBJ_W-1:0]                 objIdx;
  logic [LANE_COUNT-1:0][POS_W-1:0] rdBytes;
  logic                             winHit;
  logic                             wrEn;

  // CPU write decode: window select, lane 3 unused, CPU owns the store in blanking
  assign winHit = (cpuAddr[WIN_LO+2:WIN_LO] == WIN_SEL);
  assign wrEn   = cpuWr && winHit && blank && (cpuAddr[1:0] != 2'd3);

  sprObjRam #(
    .OBJ_COUNT(OBJ_COUNT),
    .BYTE_W   (POS_W)
  ) uRam (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrObj  (cpuAddr[OBJ_W+1:2]),
    .wrLane (cpuAddr[1:0]),
    .wrData (cpuData),
    .rdSel  (ramSel),
    .rdObj  (objIdx),
    .rdBytes(rdBytes)
  );

  sprAddrCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .blank    (blank),
    .renderReq(renderReq),
    .strobes  (strobes),
    .ramSel   (ramSel)
  );

  sprAddrPath #(
    .OBJ_COUNT(OBJ_COUNT),
    .POS_W    (POS_W),
    .CODE_W   (CODE_W),
    .ROW_W    (ROW_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .renderObj(renderObj),
    .scanLine (scanLine),
    .rdBytes  (rdBytes),
    .objIdx   (objIdx),
    .romAddr  (romAddr),
    .romValid (romValid),
    .romX     (romX)
  );

  // R8: the select is a single-cycle pulse
  a_r8_sel_single: assert property (@(posedge clk) disable iff (!rstN)
    ramSel |=> !ramSel);

  // R6: beats appear only in the two cycles after a select
  a_r6_beat_after_sel: assert property (@(posedge clk) disable iff (!rstN)
    (romValid && !romAddr[0]) |-> $past(ramSel));

endmodule

// File: tb/spriteAddrGen_test.sv
`timescale 1ns/1ps
module spriteAddrGen_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic [13:0] cpuAddr;
  logic [7:0]  cpuData;
  logic        cpuWr;
  logic        blank;
  logic        renderReq;
  logic [5:0]  renderObj;
  logic [7:0]  scanLine;
  logic [12:0] romAddr;
  logic        romValid;
  logic [7:0]  romX;
  logic        ramSel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] expCode [64];
  logic [7:0] expV    [64];
  logic [7:0] expX    [64];

  always #4 clk = ~clk;

  spriteAddrGen uut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuData(cpuData), .cpuWr(cpuWr),
    .blank(blank), .renderReq(renderReq), .renderObj(renderObj), .scanLine(scanLine),
    .romAddr(romAddr), .romValid(romValid), .romX(romX), .ramSel(ramSel)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic [13:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuData = d; cpuWr = 1'b1;
    @(negedge clk);
    cpuWr = 1'b0;
  endtask

  // one request; captures the outputs at each stage
  task automatic doRender(input logic [5:0] obj, input logic [7:0] line,
                          output logic selOk, output logic v0, output logic [12:0] a0,
                          output logic [7:0] x0, output logic v1, output logic [12:0] a1,
                          output logic tailOk);
    @(negedge clk);
    renderObj = obj; scanLine = line; renderReq = 1'b1;
    @(negedge clk);
    renderReq = 1'b0;
    selOk = ramSel && !romValid;
    @(negedge clk);
    v0 = romValid; a0 = romAddr; x0 = romX;
    selOk = selOk && !ramSel;
    @(negedge clk);
    v1 = romValid; a1 = romAddr;
    @(negedge clk);
    tailOk = !romValid && !ramSel && (romAddr[12:1] == 12'hFFF);
  endtask

  // render and compare against the arithmetic model
  task automatic renderCheck(input logic [5:0] obj, input logic [7:0] line, input string tag);
    logic selOk, v0, v1, tailOk;
    logic [12:0] a0, a1;
    logic [7:0] x0, row;
    bit hit;
    row = line - expV[obj];
    hit = (row < 8'd16);
    doRender(obj, line, selOk, v0, a0, x0, v1, a1, tailOk);
    chk(selOk, {tag, " R8 select pulse"}, {31'd0, selOk}, 32'd1);
    if (hit) begin
      chk(v0 && a0 == {~expCode[obj], row[3:0], 1'b0} && x0 == expX[obj],
          {tag, " R5 R6 first beat"}, {v0, a0, x0}, {1'b1, ~expCode[obj], row[3:0], 1'b0, expX[obj]});
      chk(v1 && a1 == {~expCode[obj], row[3:0], 1'b1},
          {tag, " R6 second beat"}, {v1, a1}, {1'b1, ~expCode[obj], row[3:0], 1'b1});
    end else begin
      chk(!v0 && !v1 && a0[12:1] == 12'hFFF && a1[12:1] == 12'hFFF && x0 == 8'd0,
          {tag, " R7 R9 miss stays idle"}, {v0, v1, a0}, {2'b00, 13'h1FFE});
    end
    chk(tailOk, {tag, " R9 idle after pair"}, {31'd0, tailOk}, 32'd1);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic selOk, v0, v1, tailOk;
    logic [12:0] a0, a1;
    logic [7:0] x0;
    rstN = 1'b0; cpuAddr = '0; cpuData = '0; cpuWr = 1'b0; blank = 1'b1;
    renderReq = 1'b0; renderObj = '0; scanLine = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!romValid && !ramSel && romAddr[12:1] == 12'hFFF, "R1 reset outputs",
        {ramSel, romValid, romAddr}, {2'b00, 13'h1FFE});

    // R2 fill every object through the window during blanking
    for (int i = 0; i < 64; i++) begin
      expCode[i] = 8'(i * 37 + 5);
      expV[i]    = 8'(i * 3 + 1);
      expX[i]    = 8'(i * 5 + 2);
      cpuWrite(14'h3000 | 14'(i << 2) | 14'd0, expV[i]);
      cpuWrite(14'h3000 | 14'(i << 2) | 14'd1, expX[i]);
      cpuWrite(14'h3000 | 14'(i << 2) | 14'd2, expCode[i]);
    end
    expCode[0] = 8'h28; expV[0] = 8'h10; expX[0] = 8'h40;
    cpuWrite(14'h3000, 8'h10);
    cpuWrite(14'h3001, 8'h40);
    cpuWrite(14'h3002, 8'h28);
    @(negedge clk); blank = 1'b0;

    // R5 worked example and R11 full sprite sweep
    doRender(6'd0, 8'h10, selOk, v0, a0, x0, v1, a1, tailOk);
    chk(v0 && a0 == 13'h1AE0, "R5 code 0x28 row 0", {19'd0, a0}, 32'h1AE0);
    for (int k = 0; k < 16; k++) begin
      doRender(6'd0, 8'(8'h10 + k), selOk, v0, a0, x0, v1, a1, tailOk);
      chk(v0 && v1 && a0 == 13'(13'h1AE0 + 2 * k) && a1 == 13'(13'h1AE1 + 2 * k),
          "R11 consecutive sprite addresses", {a0, a1}, {13'(13'h1AE0 + 2 * k), 13'(13'h1AE1 + 2 * k)});
    end

    // R7 every object across its rows and both boundaries (and line wrap)
    for (int i = 0; i < 64; i++) begin
      for (int d = -2; d < 18; d++) begin
        renderCheck(6'(i), 8'(expV[i] + d), "R7 sweep");
      end
    end

    // R5 all codes on one object
    for (int c = 0; c < 256; c++) begin
      @(negedge clk); blank = 1'b1;
      expCode[63] = 8'(c);
      cpuWrite(14'h30FE, 8'(c));
      @(negedge clk); blank = 1'b0;
      renderCheck(6'd63, 8'(expV[63] + (c % 16)), "R5 code sweep");
    end

    // R3 writes outside the window are dropped
    @(negedge clk); blank = 1'b1;
    cpuWrite(14'h3802, 8'h55);
    cpuWrite(14'h1002, 8'h66);
    cpuWrite(14'h3800, 8'h99);
    @(negedge clk); blank = 1'b0;
    renderCheck(6'd0, 8'h13, "R3 window miss");

    // R4 writes during active video are dropped
    cpuWrite(14'h3002, 8'h77);
    cpuWrite(14'h3000, 8'h00);
    cpuWrite(14'h3001, 8'h11);
    renderCheck(6'd0, 8'h1F, "R4 active video write");

    // R2 lane 3 stores nothing in neighbouring lanes or objects
    @(negedge clk); blank = 1'b1;
    cpuWrite(14'h3003, 8'hC3);
    @(negedge clk); blank = 1'b0;
    renderCheck(6'd0, 8'h14, "R2 lane 3 obj0");
    renderCheck(6'd1, expV[1], "R2 lane 3 obj1");

    // R10 request during blanking is dropped
    @(negedge clk); blank = 1'b1;
    renderObj = 6'd0; scanLine = 8'h10; renderReq = 1'b1;
    @(negedge clk); renderReq = 1'b0;
    begin
      bit quiet = 1'b1;
      for (int t = 0; t < 4; t++) begin
        if (ramSel || romValid) quiet = 1'b0;
        @(negedge clk);
      end
      chk(quiet, "R10 request in blanking", {31'd0, quiet}, 32'd1);
    end
    blank = 1'b0;

    // R10 request while busy is dropped: hold the request for two samples
    @(negedge clk);
    renderObj = 6'd0; scanLine = 8'h10; renderReq = 1'b1;
    @(negedge clk);
    @(negedge clk); renderReq = 1'b0;
    chk(romValid && romAddr == 13'h1AE0, "R10 first request served", {19'd0, romAddr}, 32'h1AE0);
    @(negedge clk);
    chk(romValid && romAddr == 13'h1AE1, "R6 second half served", {19'd0, romAddr}, 32'h1AE1);
    begin
      bit quiet = 1'b1;
      for (int t = 0; t < 4; t++) begin
        @(negedge clk);
        if (ramSel || romValid) quiet = 1'b0;
      end
      chk(quiet, "R10 busy request dropped", {31'd0, quiet}, 32'd1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule